// File: doc/BRIEF.md
# General-Purpose I/O Port with Half-Cycle Input Synchronizer

This block is a parameterized general-purpose I/O port, eight bits wide by default. Each pin has three bits of state:

- a direction bit;
- an output-value bit, which also requests a pull-up while the pin is an input;
- a read-only pin-value bit that shows the sampled pad level.

For every pin the block drives three lines to an external pad model: an output-enable, an output value and a pull-up enable. A single global input disables every pull-up at once.

The raw pad level comes back through a two-stage synchronizer. The first stage follows the pad while the clock is high and freezes it on the falling edge. A rising-edge flop then loads the frozen value into the pin-value register. Because the first stage closes half a period before the flop, a pad change reaches software in one period or less when it arrives during the high phase. It never takes more than one and a half periods.

Software reaches the three registers through a small port. The port has a 2-bit select, a write strobe, write data and a combinational read-data output.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction and output registers read as all zeros, every pad_oe_o and pad_pu_o bit is 0, and every pin floats as an input.
- R2: With wr_en_i high on a rising edge, select 0 loads wdata_i into the direction register and select 1 loads it into the output register. rdata_o returns the selected register in the same cycle, with no clock edge in between.
- R3: Writes at select 2 (pin value) and select 3 (unused) change no register. Reads at select 3 return all zeros.
- R4: A pin whose direction bit is 1 has pad_oe_o=1 and pad_pu_o=0, whatever pud_i is. pad_out_o always equals the pin's output-register bit.
- R5: A pin with direction 0, output bit 1 and pud_i=0 has pad_pu_o=1 and pad_oe_o=0.
- R6: A pin with direction 0 has pad_pu_o=0 when its output bit is 0 or when pud_i=1.
- R7: The pin-value register reads at select 2 and follows the pad whatever the direction bit is.
- R8: An external pad change is captured on the first falling edge after it. It shows at select 2 after the rising edge that follows. A change during the high phase is visible within one period; a change during the low phase takes up to one and a half periods.
- R9: When software writes the output register of an output pin, the new level shows at select 2 exactly one period after the write edge. A read in the cycle right after the write returns the old level.
- R10: The pin-value register stays at zero while reset is asserted, whatever the pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pud_i | input | 1 | Global pull-up disable |
| sel_i | input | 2 | Register select: 0 direction, 1 output, 2 pin value, 3 unused |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data for the selected register |
| pad_i | input | WIDTH | Raw pad level |
| pad_oe_o | output | WIDTH | Per-pin output enable |
| pad_out_o | output | WIDTH | Per-pin output value |
| pad_pu_o | output | WIDTH | Per-pin pull-up enable |

## Verification
The bench builds the port at its default width of eight pins. Bit-mixed patterns of 8'hF0 and 8'hCC then put all four direction/output pairs on different pins in the same cycle, under both settings of the global disable. Pad changes are placed early and late in the high phase and early and late in the low phase. This shows both ends of the latency window around the falling-edge capture point. A write followed by an immediate read-back separates the exact one-period software path from the external path.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } gpio_sel_e;

  localparam int SEL_W = 2;

endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  gpio_pkg::gpio_sel_e  sel_i,
  input  logic [WIDTH-1:0]     wdata_i,
  output logic [WIDTH-1:0]     dir_o,
  output logic [WIDTH-1:0]     out_o
);
  import gpio_pkg::*;

  logic [WIDTH-1:0] dir_q, dir_d;
  logic [WIDTH-1:0] out_q, out_d;
  logic             dir_ce, out_ce;

  // next-state
  always_comb begin
    dir_ce = wr_en_i && (sel_i == SEL_DIR);
    out_ce = wr_en_i && (sel_i == SEL_OUT);
    dir_d  = dir_ce ? wdata_i : dir_q;
    out_d  = out_ce ? wdata_i : out_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_ce) dir_q <= dir_d;
      if (out_ce) out_q <= out_d;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;

  a_r3_pin_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (sel_i == SEL_PIN || sel_i == SEL_NONE)) |=> ($stable(dir_o) && $stable(out_o)));

  a_r2_dir_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && sel_i == SEL_DIR) |=> $stable(dir_o));

  a_r2_out_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && sel_i == SEL_OUT) |=> $stable(out_o));

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] out_i,
  input  logic             pud_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] val_o,
  output logic [WIDTH-1:0] pu_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic pu_req;
    // pull-up only when the pin is an input, its output bit asks for it,
    // and the global disable is clear
    assign pu_req   = ~dir_i[g] & out_i[g];
    assign oe_o[g]  = dir_i[g];
    assign val_o[g] = out_i[g];
    assign pu_o[g]  = pu_req & ~pud_i;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pin_o
);

  // Stage 1: high-transparent latch. The rising-edge stage only ever sees its
  // closed value, so it is modelled by its closing (falling) edge capture.
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] pin_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= pad_i;
  end

  // Stage 2: pin-value register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= hold_q;
  end

  assign pin_o = pin_q;

  a_r8_pin_tracks_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hold_q) |=> $stable(pin_o));

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pud_i,
  input  logic [1:0]       sel_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_pu_o
);
  import gpio_pkg::*;

  gpio_sel_e        sel;
  logic [WIDTH-1:0] dir_w, out_w, pin_w;

  assign sel = gpio_sel_e'(sel_i);

  gpio_ctrl_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .dir_o   (dir_w),
    .out_o   (out_w)
  );

  gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .dir_i (dir_w),
    .out_i (out_w),
    .pud_i (pud_i),
    .oe_o  (pad_oe_o),
    .val_o (pad_out_o),
    .pu_o  (pad_pu_o)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pad_i (pad_i),
    .pin_o (pin_w)
  );

  always_comb begin
    unique case (sel)
      SEL_DIR: rdata_o = dir_w;
      SEL_OUT: rdata_o = out_w;
      SEL_PIN: rdata_o = pin_w;
      default: rdata_o = '0;
    endcase
  end

  a_r4_output_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o & pad_pu_o) == '0);

  a_r6_disable_kills_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    pud_i |-> (pad_pu_o == '0));

  a_r2_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 2'd0) |-> (rdata_o == pad_oe_o));

  a_r3_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 2'd3) |-> (rdata_o == '0));

endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pud;
  logic [1:0]   sel;
  logic         wr_en;
  logic [W-1:0] wdata, rdata, oe, pout, pu, ext, pad;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // pad model: driven pins reflect their own output, others follow the outside
  for (genvar g = 0; g < W; g++) begin : g_pad
    assign pad[g] = oe[g] ? pout[g] : ext[g];
  end

  gpio_port #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pud_i(pud), .sel_i(sel), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad),
    .pad_oe_o(oe), .pad_out_o(pout), .pad_pu_o(pu)
  );

  // {dir, out, pud, exp_oe, exp_out, exp_pu}
  localparam logic [5:0] VEC [8] = '{
    6'b000_000, 6'b001_000, 6'b010_011, 6'b011_010,
    6'b100_100, 6'b101_100, 6'b110_110, 6'b111_110
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(posedge clk); #1;
    sel = s; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] s, input logic [W-1:0] exp);
    sel = s; #1;
    chk(req, rdata, exp);
  endtask

  function automatic logic [W-1:0] exp_field(input logic [W-1:0] d, input logic [W-1:0] o,
                                             input logic p, input int fld);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = VEC[{d[i], o[i], p}][fld];
    return r;
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pud = 1'b0; sel = 2'd0; wr_en = 1'b0; wdata = '0; ext = 8'hA5;
    repeat (3) @(posedge clk);
    #2;
    // R1 / R10 during reset
    chk("R1 oe in reset", oe, '0);
    chk("R1 pu in reset", pu, '0);
    rd_chk("R10 pin in reset", 2'd2, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    rd_chk("R1 dir after reset", 2'd0, '0);
    rd_chk("R1 out after reset", 2'd1, '0);

    // truth-table walk: every pin gets the same combination
    for (int k = 0; k < 8; k++) begin
      logic [5:0] v;
      v = VEC[k];
      pud = v[3];
      wr(2'd0, {W{v[5]}});
      wr(2'd1, {W{v[4]}});
      #2;
      chk("R4 R5 R6 oe table", oe, {W{v[2]}});
      chk("R4 pad_out table", pout, {W{v[1]}});
      chk("R5 R6 pu table", pu, {W{v[0]}});
    end

    // mixed pins: all pairs of dir/out at once, both pud settings
    wr(2'd0, 8'hF0);
    wr(2'd1, 8'hCC);
    rd_chk("R2 dir readback", 2'd0, 8'hF0);
    rd_chk("R2 out readback", 2'd1, 8'hCC);
    for (int p = 0; p < 2; p++) begin
      pud = p[0]; #2;
      chk("R4 mixed oe", oe, exp_field(8'hF0, 8'hCC, p[0], 2));
      chk("R4 mixed out", pout, exp_field(8'hF0, 8'hCC, p[0], 1));
      chk(p ? "R6 mixed pu disabled" : "R5 mixed pu", pu, exp_field(8'hF0, 8'hCC, p[0], 0));
    end
    pud = 1'b0;

    // R3: writes to pin-value and unused selects are ignored
    wr(2'd2, 8'h3C);
    wr(2'd3, 8'h5A);
    rd_chk("R3 dir unchanged", 2'd0, 8'hF0);
    rd_chk("R3 out unchanged", 2'd1, 8'hCC);
    rd_chk("R3 unused reads zero", 2'd3, '0);
    chk("R3 oe unchanged", oe, 8'hF0);

    // R7: pin value readable with mixed directions (upper pins driven 1100, lower ext)
    ext = 8'h0A;
    repeat (3) @(posedge clk); #1;
    rd_chk("R7 pin with mixed dir", 2'd2, 8'hCA);

    // R8: external latency, all pins inputs
    wr(2'd0, 8'h00);
    ext = 8'h00;
    repeat (3) @(posedge clk);
    sel = 2'd2;
    // change early in high phase
    @(posedge clk); #1; ext = 8'h01;
    #8; chk("R8 high-phase early not yet", rdata, 8'h00);
    #2; chk("R8 high-phase early within one period", rdata, 8'h01);
    // change late in high phase (half-period latency)
    @(posedge clk); #4; ext = 8'h03;
    #5; chk("R8 late high not yet", rdata, 8'h01);
    #2; chk("R8 late high after half period", rdata, 8'h03);
    // change early in low phase
    @(posedge clk); #6; ext = 8'h07;
    #5; chk("R8 low-phase missed first edge", rdata, 8'h03);
    #8; chk("R8 low-phase still old", rdata, 8'h03);
    #2; chk("R8 low-phase after 1.5 periods", rdata, 8'h07);
    // change just before rising edge
    @(posedge clk); #9; ext = 8'h0F;
    #2; chk("R8 pre-edge not taken", rdata, 8'h07);
    #10; chk("R8 pre-edge visible next period", rdata, 8'h0F);

    // R9: software read-back via output pins
    ext = 8'h00;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    repeat (2) @(posedge clk); #1;
    rd_chk("R9 baseline", 2'd2, 8'h00);
    wr(2'd1, 8'h96);              // returns 1 ns after the write edge
    rd_chk("R9 next-cycle read is old", 2'd2, 8'h00);
    @(posedge clk); #1;
    chk("R9 one period after write", rdata, 8'h96);

    // R10: reset mid-run clears pin value even with pad high
    ext = 8'hFF;
    wr(2'd0, 8'h00);
    repeat (3) @(posedge clk); #1;
    rd_chk("R7 pin input high", 2'd2, 8'hFF);
    rst_n = 1'b0; #1;
    chk("R10 pin cleared by reset", rdata, 8'h00);
    repeat (2) @(posedge clk); #1;
    chk("R10 pin held during reset", rdata, 8'h00);
    chk("R1 pu off in reset", pu, 8'h00);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule